// File: doc/BRIEF.md
# Fully Associative TLB Translation Checker

This block looks up an effective address in a software-managed translation table and decides whether the access may go ahead. On each request it compares every table entry with the address and the current process ID in parallel. It then picks the result by a priority scan that starts at the lowest index. An entry whose address-space bit does not fit the kind of access is passed over. An entry that fits but refuses the access leaves a pending fault code and the scan moves on. The first entry that fits and grants the access gives the translation.

A second result on the same request serves table searches. It gives the lowest index whose address and process ID match, ignoring address space and permissions. It also gives a condition nibble that reports the summary-overflow input and whether a match was found. The table contents arrive on a wide flat input, so the block stores no entries itself. All results are registered and are marked by a one-cycle done pulse.

Top module: `tlb_xlate_chk`

## Requirements
- R1: Entry i sits at `tbl_flat[i*66 +: 66]`. Its fields run from MSB to LSB: valid (1), pid (8), page number (22), size code (4), space bit (1), real page number (22), permissions (8). An entry address-matches when it is valid, when its pid equals `cur_pid` or is zero, and when its page number equals the page-number bits of `ea[31:10]` that lie above the page offset.
- R2: A size code k gives a page of 1 KiB × 4^k, so the low 2k bits of the 22-bit page number form part of the offset. On a hit, `ra` takes the real page number of the entry for the page bits and `ea` for every offset bit.
- R3: Entries are visited from index 0 upward. The first visited entry that grants the access gives the hit, and entries above it have no effect.
- R4: The nibble in use is perm[3:0] when `user_mode` is 1 and perm[7:4] when it is 0. Within a nibble, bit 0 allows read, bit 1 allows write and bit 2 allows execute.
- R5: On a fetch (`is_fetch`=1) an address-matched entry counts only when its space bit equals `i_space`. On a data access it counts only when its space bit equals `d_space`. Entries that do not count change no result.
- R6: On a fetch, a counted entry without execute permission sets the pending fault to execute-denied, and the scan goes on to later entries.
- R7: A data read needs read permission and a data write (`is_write`=1) needs write permission. A counted entry without it sets the pending fault to access-denied, and the scan goes on.
- R8: The fault codes are 0 for hit, 1 for miss, 2 for access-denied and 3 for execute-denied. When no entry counts, the result is a miss with `perm`=0. `hit`=1 exactly when the fault is 0, `ra` is 0 on any result that is not a hit, and `perm` is the nibble of the last counted entry visited.
- R9: `srch_idx` gives the lowest address-matched index. When nothing matches it is all ones (SIDX_W bits wide, one bit wider than an index).
- R10: When `srch_rec`=1, `cond` is {2'b00, found, so_in}. When `srch_rec`=0, `cond` is 0.
- R11: All results load on the clock edge at which `req`=1 and hold otherwise. `done` is 1 for only the cycle after that edge. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe |
| ea | input | 32 | Effective address |
| cur_pid | input | 8 | Current process ID |
| is_write | input | 1 | Data write (0 = read) |
| is_fetch | input | 1 | Instruction fetch |
| user_mode | input | 1 | 1 = user, 0 = supervisor |
| i_space | input | 1 | Address-space bit for fetches |
| d_space | input | 1 | Address-space bit for data |
| srch_rec | input | 1 | Record variant of search |
| so_in | input | 1 | Summary-overflow bit |
| tbl_flat | input | ENTRIES*66 | Packed table entries |
| done | output | 1 | Result-valid pulse |
| hit | output | 1 | Translation granted |
| ra | output | 32 | Real address |
| perm | output | 4 | Selected permission nibble |
| fault | output | 2 | Fault code |
| srch_idx | output | SIDX_W | Search index or all ones |
| cond | output | 4 | Search condition nibble |

## Verification
The bench builds the block with ENTRIES=8, so SIDX_W is 4 and a failed search reads 15. At this size every path through the scan fits in a small table that is written out by hand. That covers an early denial followed by a later grant, several denials with no grant, a matching entry skipped for its address space, an invalid entry in front of a valid one, a global process ID, and a large page that joins address bits from both sources.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
    localparam int ADDR_W = 32;
    localparam int PID_W  = 8;
    localparam int OFF_W  = 10;
    localparam int PN_W   = ADDR_W - OFF_W;

    typedef struct packed {
        logic             vld;
        logic [PID_W-1:0] pid;
        logic [PN_W-1:0]  vpn;
        logic [3:0]       szc;
        logic             spc;
        logic [PN_W-1:0]  rpn;
        logic [7:0]       perm;
    } tlbx_ent_t;

    localparam int ENT_W = $bits(tlbx_ent_t);

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_MISS = 2'd1,
        FLT_ACC  = 2'd2,
        FLT_EXE  = 2'd3
    } tlbx_flt_e;

    // page-number bits that must compare; low 2k bits belong to the offset
    function automatic logic [PN_W-1:0] pn_mask(input logic [3:0] k);
        logic [PN_W-1:0] ones;
        ones = '1;
        return ones << {k, 1'b0};
    endfunction
endpackage

// File: rtl/tlbx_ent_cmp.sv
module tlbx_ent_cmp
    import tlbx_pkg::*;
(
    input  tlbx_ent_t         ent,
    input  logic [ADDR_W-1:0] ea,
    input  logic [PID_W-1:0]  cur_pid,
    input  logic              is_write,
    input  logic              is_fetch,
    input  logic              user_mode,
    input  logic              i_space,
    input  logic              d_space,
    output logic              amatch,
    output logic              counted,
    output logic              grant,
    output logic [3:0]        nib,
    output logic [ADDR_W-1:0] ra_cand
);
    logic [PN_W-1:0] msk;
    logic [PN_W-1:0] ea_pn;
    logic            pid_ok;
    logic            spc_want;

    always_comb begin
        msk      = pn_mask(ent.szc);
        ea_pn    = ea[ADDR_W-1:OFF_W];
        pid_ok   = (ent.pid == cur_pid) || (ent.pid == '0);
        amatch   = ent.vld && pid_ok && (((ea_pn ^ ent.vpn) & msk) == '0);
        spc_want = is_fetch ? i_space : d_space;
        counted  = amatch && (ent.spc == spc_want);
        nib      = user_mode ? ent.perm[3:0] : ent.perm[7:4];
        if (is_fetch)
            grant = nib[2];
        else if (is_write)
            grant = nib[1];
        else
            grant = nib[0];
        ra_cand  = {(ent.rpn & msk) | (ea_pn & ~msk), ea[OFF_W-1:0]};
    end
endmodule

// File: rtl/tlbx_pick.sv
module tlbx_pick
    import tlbx_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int SIDX_W  = $clog2(ENTRIES) + 1
) (
    input  logic [ENTRIES-1:0]             amatch,
    input  logic [ENTRIES-1:0]             counted,
    input  logic [ENTRIES-1:0]             grant,
    input  logic [ENTRIES-1:0][3:0]        nib,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] ra_cand,
    input  logic                           is_fetch,
    output logic                           hit,
    output tlbx_flt_e                      fault,
    output logic [3:0]                     perm,
    output logic [ADDR_W-1:0]              ra,
    output logic                           found,
    output logic [SIDX_W-1:0]              sidx
);
    logic stop;

    always_comb begin
        hit   = 1'b0;
        fault = FLT_MISS;
        perm  = '0;
        ra    = '0;
        stop  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!stop && counted[i]) begin
                perm = nib[i];
                if (grant[i]) begin
                    hit   = 1'b1;
                    fault = FLT_NONE;
                    ra    = ra_cand[i];
                    stop  = 1'b1;
                end else begin
                    fault = is_fetch ? FLT_EXE : FLT_ACC;
                end
            end
        end
    end

    always_comb begin
        found = 1'b0;
        sidx  = '1;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && amatch[i]) begin
                found = 1'b1;
                sidx  = SIDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
    import tlbx_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int SIDX_W  = $clog2(ENTRIES) + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req,
    input  logic [31:0]              ea,
    input  logic [7:0]               cur_pid,
    input  logic                     is_write,
    input  logic                     is_fetch,
    input  logic                     user_mode,
    input  logic                     i_space,
    input  logic                     d_space,
    input  logic                     srch_rec,
    input  logic                     so_in,
    input  logic [ENTRIES*66-1:0]    tbl_flat,
    output logic                     done,
    output logic                     hit,
    output logic [31:0]              ra,
    output logic [3:0]               perm,
    output logic [1:0]               fault,
    output logic [SIDX_W-1:0]        srch_idx,
    output logic [3:0]               cond
);
    logic [ENTRIES-1:0]             amatch, counted, grant;
    logic [ENTRIES-1:0][3:0]        nib;
    logic [ENTRIES-1:0][ADDR_W-1:0] ra_cand;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tlbx_ent_cmp u_cmp (
            .ent      (tlbx_ent_t'(tbl_flat[g*ENT_W +: ENT_W])),
            .ea       (ea),
            .cur_pid  (cur_pid),
            .is_write (is_write),
            .is_fetch (is_fetch),
            .user_mode(user_mode),
            .i_space  (i_space),
            .d_space  (d_space),
            .amatch   (amatch[g]),
            .counted  (counted[g]),
            .grant    (grant[g]),
            .nib      (nib[g]),
            .ra_cand  (ra_cand[g])
        );
    end

    logic              n_hit, n_found;
    tlbx_flt_e         n_fault;
    logic [3:0]        n_perm;
    logic [ADDR_W-1:0] n_ra;
    logic [SIDX_W-1:0] n_sidx;

    tlbx_pick #(.ENTRIES(ENTRIES), .SIDX_W(SIDX_W)) u_pick (
        .amatch  (amatch),
        .counted (counted),
        .grant   (grant),
        .nib     (nib),
        .ra_cand (ra_cand),
        .is_fetch(is_fetch),
        .hit     (n_hit),
        .fault   (n_fault),
        .perm    (n_perm),
        .ra      (n_ra),
        .found   (n_found),
        .sidx    (n_sidx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            hit      <= 1'b0;
            ra       <= '0;
            perm     <= '0;
            fault    <= FLT_NONE;
            srch_idx <= '0;
            cond     <= '0;
        end else begin
            done <= req;
            if (req) begin
                hit      <= n_hit;
                ra       <= n_ra;
                perm     <= n_perm;
                fault    <= n_fault;
                srch_idx <= n_sidx;
                cond     <= srch_rec ? {2'b00, n_found, so_in} : 4'b0000;
            end
        end
    end
endmodule

// File: rtl/tlbx_chk.sv
module tlbx_chk #(
    parameter int SIDX_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              is_write,
    input logic              is_fetch,
    input logic              srch_rec,
    input logic              so_in,
    input logic              done,
    input logic              hit,
    input logic [31:0]       ra,
    input logic [3:0]        perm,
    input logic [1:0]        fault,
    input logic [SIDX_W-1:0] srch_idx,
    input logic [3:0]        cond
);
    AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req |=> done);                                             // R11
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req |=> (!done && $stable(ra) && $stable(fault) && $stable(srch_idx))); // R11
    AST_HIT_IFF_OK: assert property (@(posedge clk) disable iff (rst)
        done |-> (hit == (fault == 2'd0)));                        // R8
    AST_RA_ZERO_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        (done && !hit) |-> (ra == 32'd0));                         // R8
    AST_MISS_NO_PERM: assert property (@(posedge clk) disable iff (rst)
        (done && fault == 2'd1) |-> (perm == 4'd0));               // R8
    AST_FETCH_HIT_EXEC: assert property (@(posedge clk) disable iff (rst)
        (done && hit && $past(is_fetch)) |-> perm[2]);             // R6
    AST_DATA_HIT_PERM: assert property (@(posedge clk) disable iff (rst)
        (done && hit && !$past(is_fetch)) |->
            ($past(is_write) ? perm[1] : perm[0]));                // R7
    AST_FAULT_KIND: assert property (@(posedge clk) disable iff (rst)
        (done && fault[1]) |-> (fault[0] == $past(is_fetch)));     // R6
    AST_COND_REC: assert property (@(posedge clk) disable iff (rst)
        (done && $past(srch_rec)) |->
            (cond == {2'b00, srch_idx != {SIDX_W{1'b1}}, $past(so_in)})); // R10
    AST_COND_PLAIN: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(srch_rec)) |-> (cond == 4'd0));            // R10
endmodule

bind tlb_xlate_chk tlbx_chk #(.SIDX_W(SIDX_W)) u_tlbx_chk (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .is_write(is_write),
    .is_fetch(is_fetch),
    .srch_rec(srch_rec),
    .so_in   (so_in),
    .done    (done),
    .hit     (hit),
    .ra      (ra),
    .perm    (perm),
    .fault   (fault),
    .srch_idx(srch_idx),
    .cond    (cond)
);

// File: tb/tb_tlb_xlate_chk.sv
module tb_tlb_xlate_chk;
    import tlbx_pkg::*;

    localparam int N  = 8;
    localparam int SW = $clog2(N) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic          req = 0, is_write = 0, is_fetch = 0, user_mode = 0;
    logic          i_space = 0, d_space = 0, srch_rec = 0, so_in = 0;
    logic [31:0]   ea = 0;
    logic [7:0]    cur_pid = 0;
    logic [N*66-1:0] tbl_flat;
    logic          done, hit;
    logic [31:0]   ra;
    logic [3:0]    perm, cond;
    logic [1:0]    fault;
    logic [SW-1:0] srch_idx;

    tlbx_ent_t tbl [N];
    always_comb
        for (int i = 0; i < N; i++) tbl_flat[i*66 +: 66] = tbl[i];

    tlb_xlate_chk #(.ENTRIES(N)) dut (.*);

    typedef struct {
        string      tag;
        logic       hit;
        logic [31:0] ra;
        logic [3:0] perm;
        logic [1:0] fault;
        logic [SW-1:0] sidx;
        logic [3:0] cond;
    } exp_t;

    exp_t q[$];
    int checks = 0, fails = 0;

    task automatic fail_line(string tag, string what, logic [31:0] act, logic [31:0] exp);
        fails++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    // driver: one request with its expected result
    task automatic apply(string tag, logic [31:0] a, logic [7:0] p, logic w, logic f,
                         logic u, logic isp, logic dsp, logic rec, logic so,
                         logic e_hit, logic [31:0] e_ra, logic [3:0] e_perm,
                         logic [1:0] e_flt, logic [SW-1:0] e_idx, logic [3:0] e_cond);
        exp_t e;
        e.tag = tag; e.hit = e_hit; e.ra = e_ra; e.perm = e_perm;
        e.fault = e_flt; e.sidx = e_idx; e.cond = e_cond;
        q.push_back(e);
        ea = a; cur_pid = p; is_write = w; is_fetch = f; user_mode = u;
        i_space = isp; d_space = dsp; srch_rec = rec; so_in = so;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (q.size() == 0) begin
                checks++;
                fail_line("R11", "unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (hit   !== e.hit)   fail_line(e.tag, "hit",   32'(hit),   32'(e.hit));
                if (ra    !== e.ra)    fail_line(e.tag, "ra",    ra,         e.ra);
                if (perm  !== e.perm)  fail_line(e.tag, "perm",  32'(perm),  32'(e.perm));
                if (fault !== e.fault) fail_line(e.tag, "fault", 32'(fault), 32'(e.fault));
                if (srch_idx !== e.sidx) fail_line(e.tag, "srch_idx", 32'(srch_idx), 32'(e.sidx));
                if (cond  !== e.cond)  fail_line(e.tag, "cond",  32'(cond),  32'(e.cond));
            end
        end
    end

    function automatic tlbx_ent_t mk(logic v, logic [7:0] p, logic [21:0] vpn, logic [3:0] k,
                                     logic s, logic [21:0] rpn, logic [7:0] pm);
        tlbx_ent_t t;
        t.vld = v; t.pid = p; t.vpn = vpn; t.szc = k; t.spc = s; t.rpn = rpn; t.perm = pm;
        return t;
    endfunction

    initial begin
        int wd;
        wd = 0;
        fork
            begin
                while (wd < 5000) begin @(posedge clk); wd++; end
                checks++;
                fail_line("WDOG", "timeout", 32'd1, 32'd0);
            end
            begin
                tbl[0] = mk(1, 8'd5, 22'h100, 0, 0, 22'h0ABC, 8'h10);
                tbl[1] = mk(1, 8'd0, 22'h100, 0, 0, 22'h0DEF, 8'h35);
                tbl[2] = mk(1, 8'd7, 22'h200, 0, 1, 22'h0333, 8'h77);
                tbl[3] = mk(1, 8'd7, 22'h400, 2, 0, 22'h1230, 8'h44);
                tbl[4] = mk(0, 8'd0, 22'h600, 0, 0, 22'h0444, 8'hFF);
                tbl[5] = mk(1, 8'd9, 22'h600, 0, 0, 22'h0555, 8'h22);
                tbl[6] = mk(1, 8'd3, 22'h800, 0, 0, 22'h0777, 8'h00);
                tbl[7] = mk(1, 8'd3, 22'h800, 0, 0, 22'h0888, 8'h11);
                repeat (3) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                // R11 reset state
                checks++;
                if ({done, hit, ra, perm, fault, srch_idx, cond} !== '0)
                    fail_line("R11", "reset outputs", 32'(done) | 32'(hit) << 1 | ra, 32'd0);
                // tag, ea, pid, wr, fetch, user, is, ds, rec, so | hit, ra, perm, fault, idx, cond
                apply("R2_R3_read",      32'h0004_0123, 5, 0,0,0, 0,0, 1,0, 1, 32'h002A_F123, 4'h1, 2'd0, 0, 4'h2);
                apply("R7_R3_write",     32'h0004_0123, 5, 1,0,0, 0,0, 0,0, 1, 32'h0037_BD23, 4'h3, 2'd0, 0, 4'h0);
                apply("R4_R6_userfetch", 32'h0004_0123, 5, 0,1,1, 0,0, 0,0, 1, 32'h0037_BD23, 4'h5, 2'd0, 0, 4'h0);
                apply("R7_R8_alldeny",   32'h0004_0123, 5, 1,0,1, 0,0, 0,0, 0, 32'h0,        4'h5, 2'd2, 0, 4'h0);
                apply("R6_R9_R10_xd",    32'h0004_0000, 2, 0,1,0, 0,0, 1,1, 0, 32'h0,        4'h3, 2'd3, 1, 4'h3);
                apply("R5_skip_miss",    32'h0008_0010, 7, 0,0,0, 0,0, 1,1, 0, 32'h0,        4'h0, 2'd1, 2, 4'h3);
                apply("R5_dspace_hit",   32'h0008_0010, 7, 0,0,0, 0,1, 0,0, 1, 32'h000C_CC10, 4'h7, 2'd0, 2, 4'h0);
                apply("R5_ispace_hit",   32'h0008_0010, 7, 0,1,0, 1,0, 0,0, 1, 32'h000C_CC10, 4'h7, 2'd0, 2, 4'h0);
                apply("R2_bigpage",      32'h0010_2955, 7, 0,1,0, 0,0, 0,0, 1, 32'h0048_E955, 4'h4, 2'd0, 3, 4'h0);
                apply("R8_R9_miss_none", 32'h0010_4000, 7, 0,0,0, 0,0, 1,0, 0, 32'h0,        4'h0, 2'd1, 4'hF, 4'h0);
                apply("R1_invalid_miss", 32'h0018_0000, 4, 0,0,0, 0,0, 1,1, 0, 32'h0,        4'h0, 2'd1, 4'hF, 4'h1);
                apply("R1_pid_match",    32'h0018_0000, 9, 1,0,0, 0,0, 1,0, 1, 32'h0015_5400, 4'h2, 2'd0, 5, 4'h2);
                apply("R3_later_grant",  32'h0020_03FF, 3, 0,0,1, 0,0, 0,0, 1, 32'h0022_23FF, 4'h1, 2'd0, 6, 4'h0);
                // R11: done lasts one cycle, outputs hold
                @(negedge clk);
                checks++;
                if (done !== 1'b0) fail_line("R11", "done pulse", 32'(done), 32'd0);
                checks++;
                if (ra !== 32'h0022_23FF) fail_line("R11", "hold ra", ra, 32'h0022_23FF);
                repeat (2) @(negedge clk);
                checks++;
                if (q.size() != 0) fail_line("R11", "missing results", 32'(q.size()), 32'd0);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule